// File: doc/BRIEF.md
# Multichannel Hysteretic Threshold Alarm Unit

This block watches a stream of 16-bit unsigned conversion results, each tagged with a channel number, and checks every result against a high and a low alarm that belong to the tagged channel. Each channel has its own high threshold, low threshold and two hysteresis values, one for each threshold. These come in as static buses. An alarm turns on at one point and turns off at a different point, so a result that hovers near a threshold does not make the alarm toggle. Each alarm keeps two flags. The live flag follows the alarm. The sticky flag records that the alarm has ever fired and is cleared only by reading it.

A small read port returns three kinds of word: an overview with one bit per channel, a sticky word for each group of four channels, and a live word for each group. A single interrupt output reports that at least one sticky flag is set. The interrupt changes only at one point in the host's serial frame. That point is the sixteenth falling serial clock edge seen while the frame select is held. The serial clock edges arrive as single-cycle pulses that are already synchronised to `clk`.

A three-state frame tracker counts those edges:
- FR_IDLE moves to FR_COUNT when `frame_sel` is high.
- FR_COUNT counts `sclk_fall` pulses. On the last edge of the frame it moves to FR_HOLD and produces the update strobe. If `frame_sel` drops first, it returns to FR_IDLE (an abort).
- FR_HOLD ignores further edges and returns to FR_IDLE when `frame_sel` drops.

Top module: `thresh_alarm_top`

## Requirements
- R1: A high alarm is set when a valid result for its channel satisfies result > high_thr + high_hys. Its live bit and its sticky bit are both set after that clock edge.
- R2: A live high alarm is cleared when a result for its channel satisfies result <= high_thr - high_hys - 2. A result between the clear point and the set point leaves the live bit unchanged.
- R3: A low alarm is set when a result for its channel satisfies result < low_thr - low_hys - 1. Its live bit and its sticky bit are both set.
- R4: A live low alarm is cleared when a result for its channel satisfies result >= low_thr + low_hys + 1. A result between the set point and the clear point leaves the live bit unchanged.
- R5: The bounds are computed without wrap-around. A set point above 65535 (high) or below 0 (low) never sets its alarm. A clear point below 0 (high) or above 65535 (low) never clears its alarm.
- R6: A result changes only the flags of the channel named on `res_chan`, and only when `res_valid` is high. With `res_valid` low, no live flag changes.
- R7: A sticky bit stays set after its live bit clears. It is cleared by a read (`rd_en` high) of the sticky word that holds it. Only that word's bits are cleared. Reads of the overview or of a live word clear nothing.
- R8: If a set condition arrives in the same cycle as a read of its sticky word, the sticky bit stays set.
- R9: The read map has these addresses, decoded combinationally on `rd_data`:
  - address 0 is the overview, where bit i = high or low sticky of channel i;
  - address 1+2g is the sticky word of group g;
  - address 2+2g is the live word of group g;
  - in each group word, bit 2k+1 is the high alarm and bit 2k is the low alarm of channel 4g+k.
- R10: `alarm_irq` is loaded with the OR of all sticky bits only on the 16th `sclk_fall` pulse counted in FR_COUNT. The bits it takes are those held before that clock edge. At every other time it holds its value. A frame aborted before its 16th edge does not update it.
- R11: While `rst_n` is low, all live and sticky flags are zero and `alarm_irq` is zero. The FSM is in FR_IDLE.
- R12: After the update in a frame, further `sclk_fall` pulses do not update `alarm_irq` until `frame_sel` has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 3 | Channel tag of the result |
| res_data | input | 16 | Unsigned conversion result |
| hi_thr_bus | input | 128 | High thresholds, 16 bits per channel, channel 0 lowest |
| hi_hys_bus | input | 64 | High hysteresis, 8 bits per channel |
| lo_thr_bus | input | 128 | Low thresholds, 16 bits per channel |
| lo_hys_bus | input | 64 | Low hysteresis, 8 bits per channel |
| frame_sel | input | 1 | Serial frame active |
| sclk_fall | input | 1 | One-cycle pulse per falling serial clock edge |
| rd_en | input | 1 | Read strobe; clears the addressed sticky word |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read word |
| alarm_irq | output | 1 | Combined interrupt, active high |

## Verification
The assertions check several properties on every cycle:
- the interrupt holds except on the frame update strobe;
- on that strobe it takes the OR of the sticky flags;
- a sticky bit falls only after a read;
- a newly live alarm always has its sticky bit set;
- the live flags do not move without a result strobe;
- everything is clear while reset is held.

Only the bench scenarios can show the exact arithmetic of the four set and clear points, including the cases where a bound falls outside the 16-bit range. They also show the read map, which words a read clears, the priority of a trip over a read in the same cycle, and the aborted and extended frames. The bench shows these by sweeping every result value across each channel's bounds and comparing against bounds it computes itself.

// File: rtl/thresh_alarm_pkg.sv
package thresh_alarm_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_COUNT = 2'd1,
        FR_HOLD  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/alarm_cell.sv
module alarm_cell #(
    parameter int DW = 16,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] hi_thr,
    input  logic [HW-1:0] hi_hys,
    input  logic [DW-1:0] lo_thr,
    input  logic [HW-1:0] lo_hys,
    output logic          hi_act,
    output logic          lo_act,
    output logic          hi_set,
    output logic          lo_set
);
    // two extra bits keep every bound exact (no wrap)
    localparam int EW = DW + 2;

    logic [EW-1:0] d_w, hth_w, hhy_w, lth_w, lhy_w;
    logic          hi_clr, lo_clr;

    always_comb begin
        d_w    = EW'(data);
        hth_w  = EW'(hi_thr);
        hhy_w  = EW'(hi_hys);
        lth_w  = EW'(lo_thr);
        lhy_w  = EW'(lo_hys);
        hi_set = hit && (d_w > hth_w + hhy_w);
        hi_clr = hit && (d_w + hhy_w + EW'(2) <= hth_w);
        lo_set = hit && (d_w + lhy_w + EW'(1) < lth_w);
        lo_clr = hit && (d_w >= lth_w + lhy_w + EW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_act <= 1'b0;
            lo_act <= 1'b0;
        end else begin
            if (hi_set)      hi_act <= 1'b1;
            else if (hi_clr) hi_act <= 1'b0;
            if (lo_set)      lo_act <= 1'b1;
            else if (lo_clr) lo_act <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
    import thresh_alarm_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_sel,
    input  logic sclk_fall,
    output logic upd
);
    localparam int CNTW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(FRAME_BITS - 1);

    frame_state_e state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic            last_edge;

    assign last_edge = frame_sel && sclk_fall && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:  if (frame_sel) state_d = FR_COUNT;
            FR_COUNT: begin
                if (!frame_sel)     state_d = FR_IDLE;
                else if (last_edge) state_d = FR_HOLD;
            end
            FR_HOLD:  if (!frame_sel) state_d = FR_IDLE;
            default:  state_d = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (state_q != FR_COUNT)                 cnt_q <= '0;
        else if (frame_sel && sclk_fall && !last_edge) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        upd = 1'b0;
        unique case (state_q)
            FR_COUNT: upd = last_edge;
            default:  upd = 1'b0;
        endcase
    end
endmodule

// File: rtl/thresh_alarm_top.sv
module thresh_alarm_top #(
    parameter int NCH        = 8,
    parameter int DW         = 16,
    parameter int HW         = 8,
    parameter int FRAME_BITS = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   res_valid,
    input  logic [$clog2(NCH)-1:0]                 res_chan,
    input  logic [DW-1:0]                          res_data,
    input  logic [NCH*DW-1:0]                      hi_thr_bus,
    input  logic [NCH*HW-1:0]                      hi_hys_bus,
    input  logic [NCH*DW-1:0]                      lo_thr_bus,
    input  logic [NCH*HW-1:0]                      lo_hys_bus,
    input  logic                                   frame_sel,
    input  logic                                   sclk_fall,
    input  logic                                   rd_en,
    input  logic [$clog2(2*((NCH+3)/4)+1)-1:0]     rd_addr,
    output logic [((NCH > 8) ? NCH : 8)-1:0]       rd_data,
    output logic                                   alarm_irq
);
    localparam int CW   = $clog2(NCH);
    localparam int NGRP = (NCH + 3) / 4;
    localparam int AW   = $clog2(2*NGRP + 1);
    localparam int RDW  = (NCH > 8) ? NCH : 8;
    localparam int FW   = 2 * NCH;
    localparam int PADW = 8 * NGRP;

    // bit 2i+1 = high alarm, bit 2i = low alarm of channel i
    logic [FW-1:0]   act_vec, set_vec, trip_vec;
    logic [PADW-1:0] act_pad, trip_pad, clr_mask;
    logic [NCH-1:0]  ovw;
    logic            frame_upd;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_cell
        alarm_cell #(.DW(DW), .HW(HW)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (res_valid && (res_chan == CW'(ch))),
            .data   (res_data),
            .hi_thr (hi_thr_bus[ch*DW +: DW]),
            .hi_hys (hi_hys_bus[ch*HW +: HW]),
            .lo_thr (lo_thr_bus[ch*DW +: DW]),
            .lo_hys (lo_hys_bus[ch*HW +: HW]),
            .hi_act (act_vec[2*ch+1]),
            .lo_act (act_vec[2*ch]),
            .hi_set (set_vec[2*ch+1]),
            .lo_set (set_vec[2*ch])
        );
        assign ovw[ch] = trip_vec[2*ch+1] | trip_vec[2*ch];
    end

    frame_tracker #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_sel (frame_sel),
        .sclk_fall (sclk_fall),
        .upd       (frame_upd)
    );

    assign act_pad  = PADW'(act_vec);
    assign trip_pad = PADW'(trip_vec);

    always_comb begin
        rd_data  = '0;
        clr_mask = '0;
        if (rd_addr == '0) rd_data = RDW'(ovw);
        for (int g = 0; g < NGRP; g++) begin
            if (rd_addr == AW'(1 + 2*g)) begin
                rd_data           = RDW'(trip_pad[8*g +: 8]);
                clr_mask[8*g +: 8] = {8{rd_en}};
            end
            if (rd_addr == AW'(2 + 2*g)) rd_data = RDW'(act_pad[8*g +: 8]);
        end
    end

    // a new trip wins over a read-clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trip_vec <= '0;
        else        trip_vec <= (trip_vec & ~clr_mask[FW-1:0]) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         alarm_irq <= 1'b0;
        else if (frame_upd) alarm_irq <= |trip_vec;
    end
endmodule

// File: rtl/thresh_alarm_chk.sv
module thresh_alarm_chk #(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          res_valid,
    input logic          rd_en,
    input logic          upd,
    input logic          irq,
    input logic [FW-1:0] act,
    input logic [FW-1:0] trip
);
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(irq));

    assert_irq_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (irq == $past(|trip)));

    assert_sticky_only_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((~trip & $past(trip)) != '0) |-> $past(rd_en));

    assert_new_live_tripped_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((act & ~$past(act) & ~trip) == '0));

    assert_no_strobe_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(act));

    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |-> (!irq && act == '0 && trip == '0));
endmodule

bind thresh_alarm_top thresh_alarm_chk #(.FW(2*NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .rd_en     (rd_en),
    .upd       (frame_upd),
    .irq       (alarm_irq),
    .act       (act_vec),
    .trip      (trip_vec)
);

// File: tb/thresh_alarm_top_test.sv
`timescale 1ns/1ps
module thresh_alarm_top_test;
    localparam int NCH = 8;
    localparam int DW  = 16;
    localparam int HW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              res_valid = 1'b0;
    logic [2:0]        res_chan = '0;
    logic [DW-1:0]     res_data = '0;
    logic [NCH*DW-1:0] hi_thr_bus = '0, lo_thr_bus = '0;
    logic [NCH*HW-1:0] hi_hys_bus = '0, lo_hys_bus = '0;
    logic              frame_sel = 1'b0, sclk_fall = 1'b0, rd_en = 1'b0;
    logic [2:0]        rd_addr = '0;
    logic [7:0]        rd_data;
    logic              alarm_irq;

    int total = 0, bad = 0;
    int hthr [NCH], hhys [NCH], lthr [NCH], lhys [NCH];
    bit m_hact [NCH], m_lact [NCH], m_htr [NCH], m_ltr [NCH];

    always #2 clk = ~clk;

    thresh_alarm_top uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .hi_thr_bus(hi_thr_bus), .hi_hys_bus(hi_hys_bus),
        .lo_thr_bus(lo_thr_bus), .lo_hys_bus(lo_hys_bus), .frame_sel(frame_sel),
        .sclk_fall(sclk_fall), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input int actual, input int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    function automatic int exp_word(input int addr);
        int w = 0;
        if (addr == 0) begin
            for (int i = 0; i < NCH; i++) if (m_htr[i] || m_ltr[i]) w |= (1 << i);
        end else begin
            int g = (addr - 1) / 2;
            for (int k = 0; k < 4; k++) begin
                int c = 4*g + k;
                if (addr % 2 == 1) begin
                    if (m_htr[c]) w |= (2 << (2*k));
                    if (m_ltr[c]) w |= (1 << (2*k));
                end else begin
                    if (m_hact[c]) w |= (2 << (2*k));
                    if (m_lact[c]) w |= (1 << (2*k));
                end
            end
        end
        return w;
    endfunction

    function automatic void model_sample(input int c, input int v);
        if (v > hthr[c] + hhys[c]) begin m_hact[c] = 1; m_htr[c] = 1; end
        else if (v <= hthr[c] - hhys[c] - 2) m_hact[c] = 0;
        if (v < lthr[c] - lhys[c] - 1) begin m_lact[c] = 1; m_ltr[c] = 1; end
        else if (v >= lthr[c] + lhys[c] + 1) m_lact[c] = 0;
    endfunction

    function automatic void model_clear_read(input int addr);
        if (addr % 2 == 1 && addr <= 3)
            for (int k = 0; k < 4; k++) begin
                m_htr[4*((addr-1)/2)+k] = 0;
                m_ltr[4*((addr-1)/2)+k] = 0;
            end
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_hact[i] = 0; m_lact[i] = 0; m_htr[i] = 0; m_ltr[i] = 0;
        end
    endfunction

    task automatic peek_check(input string req, input int addr);
        rd_addr = 3'(addr);
        #1;
        check(req, int'(rd_data), exp_word(addr));
    endtask

    task automatic send(input int c, input int v);
        @(negedge clk);
        res_valid = 1'b1; res_chan = 3'(c); res_data = 16'(v);
        @(negedge clk);
        res_valid = 1'b0;
        model_sample(c, v);
    endtask

    task automatic read_clear(input int addr);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        model_clear_read(addr);
    endtask

    task automatic edge_pulse();
        @(negedge clk); sclk_fall = 1'b1;
        @(negedge clk); sclk_fall = 1'b0;
    endtask

    task automatic sweep(input int c, input int lo, input int hi);
        int ga = 2 + 2*(c/4), gt = 1 + 2*(c/4);
        for (int v = lo; v <= hi; v++) begin
            send(c, v);
            peek_check("R1/R2/R3/R4/R5 live sweep up", ga);
            peek_check("R1/R3 sticky sweep up", gt);
        end
        for (int v = hi; v >= lo; v--) begin
            send(c, v);
            peek_check("R1/R2/R3/R4/R5 live sweep down", ga);
            peek_check("R1/R3 sticky sweep down", gt);
        end
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) begin
            hthr[i] = 1000 + 50*i; hhys[i] = i + 1; lthr[i] = 300 + 20*i; lhys[i] = i;
        end
        hthr[5] = 2;     hhys[5] = 1;  lthr[5] = 300;   lhys[5] = 3;   // R5 high never clears
        hthr[6] = 1200;  hhys[6] = 4;  lthr[6] = 3;     lhys[6] = 5;   // R5 low never sets
        hthr[7] = 65530; hhys[7] = 10; lthr[7] = 65530; lhys[7] = 10;  // R5 high never sets, low never clears
        for (int i = 0; i < NCH; i++) begin
            hi_thr_bus[i*DW +: DW] = 16'(hthr[i]);
            hi_hys_bus[i*HW +: HW] = 8'(hhys[i]);
            lo_thr_bus[i*DW +: DW] = 16'(lthr[i]);
            lo_hys_bus[i*HW +: HW] = 8'(lhys[i]);
        end
        model_reset();
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 irq in reset", int'(alarm_irq), 0);
        for (int a = 0; a < 5; a++) peek_check("R11 flags in reset", a);
        rst_n = 1'b1;

        // R6: no strobe, extreme data, no change
        @(negedge clk);
        res_chan = 3'd1; res_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        res_data = 16'h0000;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 5; a++) peek_check("R6 ignored without strobe", a);

        // R1..R5 sweeps, R6 other channels untouched
        for (int c = 0; c < 7; c++) begin
            sweep(c, 0, 1600);
            for (int a = 0; a < 5; a++) peek_check("R6 only tagged channel", a);
        end
        sweep(7, 65300, 65535);
        check("R10 irq held without frame", int'(alarm_irq), 0);
        peek_check("R9 overview", 0);

        // R10 frame update on 16th edge
        @(negedge clk); frame_sel = 1'b1;
        for (int e = 0; e < 15; e++) edge_pulse();
        check("R10 irq before 16th edge", int'(alarm_irq), 0);
        edge_pulse();
        check("R10 irq after 16th edge", int'(alarm_irq), 1);

        // R7: clear group 0 sticky only
        read_clear(1);
        peek_check("R7 group0 sticky cleared", 1);
        peek_check("R7 group1 sticky kept", 3);
        peek_check("R7 live unaffected by read", 2);
        peek_check("R7 live unaffected by read", 4);
        read_clear(0);
        read_clear(4);
        peek_check("R7 overview read clears nothing", 0);
        peek_check("R7 live read clears nothing", 3);

        // R12: extra edges in hold, after clearing all sticky
        read_clear(3);
        peek_check("R7 all sticky cleared", 0);
        edge_pulse(); edge_pulse();
        check("R12 no update in hold", int'(alarm_irq), 1);
        @(negedge clk); frame_sel = 1'b0;
        @(negedge clk);

        // R8: trip and read in same cycle
        @(negedge clk);
        res_valid = 1'b1; res_chan = 3'd1; res_data = 16'd2000;
        rd_en = 1'b1; rd_addr = 3'd1;
        @(negedge clk);
        res_valid = 1'b0; rd_en = 1'b0;
        model_clear_read(1);
        model_sample(1, 2000);
        peek_check("R8 trip wins over read", 1);
        read_clear(1);
        peek_check("R7 cleared after trip", 0);

        // R10 aborted frame keeps irq
        @(negedge clk); frame_sel = 1'b1;
        for (int e = 0; e < 10; e++) edge_pulse();
        @(negedge clk); frame_sel = 1'b0;
        @(negedge clk);
        check("R10 aborted frame no update", int'(alarm_irq), 1);
        // full frame clears irq
        @(negedge clk); frame_sel = 1'b1;
        for (int e = 0; e < 16; e++) edge_pulse();
        check("R10 irq cleared on update", int'(alarm_irq), 0);
        @(negedge clk); frame_sel = 1'b0;

        // R11 mid-run reset
        send(3, 5000);
        peek_check("R1 trip before reset", 1);
        @(negedge clk); rst_n = 1'b0;
        model_reset();
        #1;
        for (int a = 0; a < 5; a++) peek_check("R11 flags after reset", a);
        check("R11 irq after reset", int'(alarm_irq), 0);
        @(negedge clk); rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule